// File: doc/BRIEF.md
# Pad Boundary-Scan Register

This block is the serial boundary-scan data register for a bank of general-purpose pads. Every pad gives the chain three cells, one each for its input, its output and its output-enable. One more cell watches the chip's reset input pin. That cell can be observed but can never be driven. The TAP state machine sits outside the block. It passes in a select that is high while a boundary-scan instruction owns the data path, plus one-cycle strobes for the capture, shift and update data-register states.

In a sample/preload pass, the capture strobe loads every live pad signal into the chain at once. Shift then moves the samples out on TDO while fresh test data enters from TDI. The update strobe copies the shifted-in data into a bank of parallel latches. The latched preload values are exported for the pad muxes elsewhere, which may drive them later. The reset-pin cell has no latch. With N pads the chain is 3N+1 cells long.

Top module: `pad_scan_chain`

## Requirements
- R1: While `trst_n` is low at a rising TCK edge, all chain cells and all preload latches clear to 0. TDO reads 0 after the next falling edge.
- R2: A rising edge with `tlr` high (test-logic-reset state) clears all chain cells and preload latches to 0, whatever the other strobes are doing.
- R3: A rising edge with `sel` and `capture_dr` high loads chain cell 3p with `pad_in[p]`, cell 3p+1 with `pad_out[p]` and cell 3p+2 with `pad_oe[p]`. The last cell, 3N, loads `rst_pin`. Cell 0 is nearest TDI.
- R4: A rising edge with `sel` and `shift_dr` high and `capture_dr` low moves every cell k to cell k+1 and loads cell 0 from `tdi`.
- R5: `tdo` shows the value of cell 3N, which is nearest TDO. It changes only on the falling TCK edge. After a capture, the first bit out is `rst_pin`, followed by pad N-1's output-enable, output and input, and so on down to pad 0.
- R6: A rising edge with `sel` and `update_dr` high copies cells 3p, 3p+1 and 3p+2 into `pre_in[p]`, `pre_out[p]` and `pre_oe[p]`. The values copied are the ones the cells held before that edge.
- R7: The preload latches hold their values across capture and shift and across idle cycles. Only an update, `trst_n` or `tlr` changes them.
- R8: While `sel` is low, the capture, shift and update strobes have no effect. The chain and the latches hold.
- R9: If capture and shift are both high on the same edge, capture wins.
- R10: A bit entered at TDI first appears on TDO after exactly 3N+1 shift edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low test reset |
| tlr | input | 1 | TAP is in test-logic-reset |
| sel | input | 1 | Boundary-scan instruction active |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial test data in |
| pad_in | input | NUM_PADS | Live pad input values |
| pad_out | input | NUM_PADS | Live pad output values |
| pad_oe | input | NUM_PADS | Live pad output-enable values |
| rst_pin | input | 1 | Live reset-pin level (observe only) |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| pre_in | output | NUM_PADS | Preload latch, input cells |
| pre_out | output | NUM_PADS | Preload latch, output cells |
| pre_oe | output | NUM_PADS | Preload latch, output-enable cells |

## Verification
The bench checks TDO both just after the rising edge and just after the falling edge. A design that retimed TDO on the rising edge would therefore show the new bit one half-cycle early. Serial streams are compared bit by bit against a queue model, which exposes a swapped cell order inside a pad triple or a reset cell at the wrong end. The bench also checks collisions: capture and shift on the same edge, and update and shift on the same edge. A design that gave shift priority, or latched the post-shift contents, would diverge at once. Strobes with `sel` low, and an explicit 3N+1 edge latency count, catch an ungated strobe and an off-by-one chain length.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the pad boundary-scan register.
// Assumes three cells per pad, numbered from the TDI end.
package bsr_pkg;

    typedef enum logic [1:0] {
        CELL_IN  = 2'd0,
        CELL_OUT = 2'd1,
        CELL_OE  = 2'd2
    } cell_kind_e;

    localparam int CELLS_PER_PAD = 3;

    // Chain position of a given cell of a given pad (0 = nearest TDI).
    function automatic int cell_pos(input int pad, input cell_kind_e kind);
        return CELLS_PER_PAD * pad + int'(kind);
    endfunction

endpackage

// File: rtl/bsr_shift_cell.sv
`timescale 1ns/1ps
// One capture/shift stage of the boundary-scan chain.
// Assumes capture and shift strobes are already qualified by the
// instruction select; capture has priority over shift.
module bsr_shift_cell (
    input  logic clk,
    input  logic clr_n,
    input  logic cap,
    input  logic shf,
    input  logic par_in,
    input  logic ser_in,
    output logic q
);

    // Stage flop: clear, parallel capture, or serial shift.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else if (cap) begin
            q <= par_in;
        end else if (shf) begin
            q <= ser_in;
        end
    end

endmodule

// File: rtl/bsr_update_bank.sv
`timescale 1ns/1ps
// Parallel preload latches for the pad cells of the chain.
// Assumes the stage vector excludes the observe-only reset cell and
// the update strobe is already qualified by the instruction select.
module bsr_update_bank
    import bsr_pkg::*;
#(
    parameter int NUM_PADS = 4
) (
    input  logic                              clk,
    input  logic                              clr_n,
    input  logic                              upd,
    input  logic [CELLS_PER_PAD*NUM_PADS-1:0] stage,
    output logic [NUM_PADS-1:0]               pre_in,
    output logic [NUM_PADS-1:0]               pre_out,
    output logic [NUM_PADS-1:0]               pre_oe
);

    localparam int PAD_CELLS = CELLS_PER_PAD * NUM_PADS;

    logic [PAD_CELLS-1:0] lat_q;

    // Latch bank: clear on reset, copy the stage on update, else hold.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            lat_q <= '0;
        end else if (upd) begin
            lat_q <= stage;
        end
    end

    // Unpack each pad's triple into the three export vectors.
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_unpack
        assign pre_in[p]  = lat_q[cell_pos(p, CELL_IN)];
        assign pre_out[p] = lat_q[cell_pos(p, CELL_OUT)];
        assign pre_oe[p]  = lat_q[cell_pos(p, CELL_OE)];
    end

endmodule

// File: rtl/bsr_tdo_retime.sv
`timescale 1ns/1ps
// Falling-edge retiming flop for TDO.
// Assumes the chain advances on the rising edge, so the output is
// stable for the whole low phase of the test clock.
module bsr_tdo_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Present the TDO-end cell half a cycle after it moves.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pad_scan_chain.sv
`timescale 1ns/1ps
// Boundary-scan data register for NUM_PADS pads plus an observe-only
// reset-pin cell. Assumes an external TAP controller supplies one-cycle
// state strobes and a select for boundary-scan instructions.
module pad_scan_chain
    import bsr_pkg::*;
#(
    parameter int NUM_PADS = 4
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tlr,
    input  logic                sel,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                tdi,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic [NUM_PADS-1:0] pad_out,
    input  logic [NUM_PADS-1:0] pad_oe,
    input  logic                rst_pin,
    output logic                tdo,
    output logic [NUM_PADS-1:0] pre_in,
    output logic [NUM_PADS-1:0] pre_out,
    output logic [NUM_PADS-1:0] pre_oe
);

    localparam int PAD_CELLS = CELLS_PER_PAD * NUM_PADS;
    localparam int CHAIN_LEN = PAD_CELLS + 1;
    localparam int RST_POS   = CHAIN_LEN - 1;

    logic                 clr_n;
    logic                 do_cap;
    logic                 do_shift;
    logic                 do_upd;
    logic [CHAIN_LEN-1:0] par_vec;
    logic [CHAIN_LEN-1:0] ser_vec;
    logic [CHAIN_LEN-1:0] stage_q;

    // Qualify the TAP strobes with the instruction select and merge resets.
    assign clr_n    = trst_n & ~tlr;
    assign do_cap   = sel & capture_dr;
    assign do_shift = sel & shift_dr;
    assign do_upd   = sel & update_dr;

    // Route each pad's live signals to its three chain positions.
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        assign par_vec[cell_pos(p, CELL_IN)]  = pad_in[p];
        assign par_vec[cell_pos(p, CELL_OUT)] = pad_out[p];
        assign par_vec[cell_pos(p, CELL_OE)]  = pad_oe[p];
    end
    assign par_vec[RST_POS] = rst_pin;

    // Serial feed: cell 0 takes TDI, every other cell takes its neighbour.
    assign ser_vec = {stage_q[CHAIN_LEN-2:0], tdi};

    // One capture/shift stage per chain position.
    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_cell
        bsr_shift_cell u_cell (
            .clk    (tck),
            .clr_n  (clr_n),
            .cap    (do_cap),
            .shf    (do_shift),
            .par_in (par_vec[k]),
            .ser_in (ser_vec[k]),
            .q      (stage_q[k])
        );
    end

    // Preload latches cover pad cells only; the reset cell has none.
    bsr_update_bank #(
        .NUM_PADS (NUM_PADS)
    ) u_bank (
        .clk     (tck),
        .clr_n   (clr_n),
        .upd     (do_upd),
        .stage   (stage_q[PAD_CELLS-1:0]),
        .pre_in  (pre_in),
        .pre_out (pre_out),
        .pre_oe  (pre_oe)
    );

    // TDO leaves from the reset cell end, retimed to the falling edge.
    bsr_tdo_retime u_tdo (
        .clk   (tck),
        .rst_n (trst_n),
        .d     (stage_q[RST_POS]),
        .q     (tdo)
    );

endmodule

// File: rtl/bsr_chk.sv
`timescale 1ns/1ps
// Property checker for pad_scan_chain; attached by bind below.
// Assumes the chain vector is indexed from the TDI end.
module bsr_chk #(
    parameter int NUM_PADS = 4
) (
    input logic                  clk,
    input logic                  trst_n,
    input logic                  tlr,
    input logic                  sel,
    input logic                  cap,
    input logic                  shf,
    input logic                  upd,
    input logic                  tdi,
    input logic                  rst_pin,
    input logic [3*NUM_PADS:0]   stage,
    input logic [NUM_PADS-1:0]   pin,
    input logic [NUM_PADS-1:0]   pout,
    input logic [NUM_PADS-1:0]   poe
);

    localparam int LAST = 3 * NUM_PADS;
    localparam int TOPP = NUM_PADS - 1;

    // R2
    tlr_clear_chk: assert property (@(posedge clk) disable iff (!trst_n)
        tlr |=> (pin == '0 && pout == '0 && poe == '0 && stage == '0));

    // R3
    capture_rst_chk: assert property (@(posedge clk) disable iff (!trst_n)
        (!tlr && sel && cap) |=> stage[LAST] == $past(rst_pin));

    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (!trst_n)
        (!tlr && sel && shf && !cap) |=>
            (stage[0] == $past(tdi) && stage[LAST] == $past(stage[LAST-1])));

    // R6
    update_copy_chk: assert property (@(posedge clk) disable iff (!trst_n)
        (!tlr && sel && upd) |=>
            (pin[0] == $past(stage[0]) && poe[0] == $past(stage[2]) &&
             pout[TOPP] == $past(stage[3*TOPP+1])));

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!trst_n)
        (!tlr && !(sel && upd)) |=> ($stable(pin) && $stable(pout) && $stable(poe)));

    // R8
    desel_hold_chk: assert property (@(posedge clk) disable iff (!trst_n)
        (!tlr && !sel) |=> $stable(stage));

endmodule

bind pad_scan_chain bsr_chk #(
    .NUM_PADS (NUM_PADS)
) u_bsr_chk (
    .clk     (tck),
    .trst_n  (trst_n),
    .tlr     (tlr),
    .sel     (sel),
    .cap     (capture_dr),
    .shf     (shift_dr),
    .upd     (update_dr),
    .tdi     (tdi),
    .rst_pin (rst_pin),
    .stage   (stage_q),
    .pin     (pre_in),
    .pout    (pre_out),
    .poe     (pre_oe)
);

// File: tb/tb_pad_scan_chain.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural queue model compared on every clock.
module tb_pad_scan_chain;

    localparam int NP  = 4;
    localparam int LEN = 3 * NP + 1;

    logic          tck = 1'b0;
    logic          trst_n, tlr, sel, capture_dr, shift_dr, update_dr, tdi, rst_pin;
    logic [NP-1:0] pad_in, pad_out, pad_oe;
    logic          tdo;
    logic [NP-1:0] pre_in, pre_out, pre_oe;

    pad_scan_chain #(.NUM_PADS(NP)) dut (
        .tck(tck), .trst_n(trst_n), .tlr(tlr), .sel(sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .rst_pin(rst_pin), .tdo(tdo), .pre_in(pre_in), .pre_out(pre_out),
        .pre_oe(pre_oe)
    );

    always #2.5 tck = ~tck;

    // Reference model state.
    bit            mq[$];
    logic [NP-1:0] m_in, m_out, m_oe;
    logic          m_tdo;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 0;
    string         cur = "R1";

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_rise();
        if (!trst_n || tlr) begin
            mq.delete();
            for (int k = 0; k < LEN; k++) mq.push_back(1'b0);
            m_in = '0; m_out = '0; m_oe = '0;
        end else begin
            if (sel && update_dr) begin
                for (int p = 0; p < NP; p++) begin
                    m_in[p]  = mq[3*p];
                    m_out[p] = mq[3*p+1];
                    m_oe[p]  = mq[3*p+2];
                end
            end
            if (sel && capture_dr) begin
                mq.delete();
                for (int p = 0; p < NP; p++) begin
                    mq.push_back(pad_in[p]);
                    mq.push_back(pad_out[p]);
                    mq.push_back(pad_oe[p]);
                end
                mq.push_back(rst_pin);
            end else if (sel && shift_dr) begin
                mq.push_front(tdi);
                void'(mq.pop_back());
            end
        end
    endtask

    task automatic step();
        logic old_tdo;
        @(posedge tck);
        old_tdo = m_tdo;
        model_rise();
        #0.5;
        chk({cur, " R5 tdo before fall"}, 64'(tdo), 64'(old_tdo));
        @(negedge tck);
        m_tdo = trst_n ? mq[LEN-1] : 1'b0;
        #0.5;
        chk({cur, " tdo"}, 64'(tdo), 64'(m_tdo));
        chk({cur, " pre_in"}, 64'(pre_in), 64'(m_in));
        chk({cur, " pre_out"}, 64'(pre_out), 64'(m_out));
        chk({cur, " pre_oe"}, 64'(pre_oe), 64'(m_oe));
    endtask

    task automatic idle();
        tlr = 0; capture_dr = 0; shift_dr = 0; update_dr = 0;
    endtask

    task automatic randomize_pads();
        pad_in = NP'($urandom); pad_out = NP'($urandom);
        pad_oe = NP'($urandom); rst_pin = 1'($urandom);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int edges;
        m_in = '0; m_out = '0; m_oe = '0; m_tdo = 1'b0;
        for (int k = 0; k < LEN; k++) mq.push_back(1'b0);
        trst_n = 0; sel = 0; tdi = 0; idle();
        pad_in = '1; pad_out = '1; pad_oe = '1; rst_pin = 1;

        // R1: reset state with strobes active.
        cur = "R1";
        sel = 1; capture_dr = 1;
        repeat (3) step();
        chk("R1 tdo after reset", 64'(tdo), 64'd0);
        chk("R1 pre_oe after reset", 64'(pre_oe), 64'd0);
        trst_n = 1; idle();
        step();

        // R3/R5: capture a pattern and shift it out, new data in.
        cur = "R3";
        pad_in = 4'b0101; pad_out = 4'b0011; pad_oe = 4'b1000; rst_pin = 1;
        capture_dr = 1; step(); capture_dr = 0;
        chk("R5 first bit is rst_pin", 64'(tdo), 64'd1);
        cur = "R4";
        shift_dr = 1;
        for (int i = 0; i < LEN; i++) begin
            tdi = 1'((i * 5 + 1) % 3 == 0);
            step();
        end
        shift_dr = 0;
        // R6: update copies the shifted-in data.
        cur = "R6";
        update_dr = 1; step(); update_dr = 0; step();

        // R7: latches hold across another capture and shift.
        cur = "R7";
        randomize_pads();
        capture_dr = 1; step(); capture_dr = 0;
        shift_dr = 1;
        for (int i = 0; i < 7; i++) begin tdi = 1'($urandom); step(); end
        shift_dr = 0;

        // R6: update on the same edge as a shift copies pre-shift contents.
        cur = "R6 with shift";
        shift_dr = 1; update_dr = 1; tdi = 1; step();
        shift_dr = 0; update_dr = 0; step();

        // R8: deselected strobes have no effect.
        cur = "R8";
        sel = 0;
        randomize_pads();
        capture_dr = 1; step(); capture_dr = 0;
        shift_dr = 1; tdi = ~tdo; repeat (3) step(); shift_dr = 0;
        update_dr = 1; step(); update_dr = 0;
        sel = 1;

        // R9: capture and shift together, capture wins.
        cur = "R9";
        randomize_pads();
        capture_dr = 1; shift_dr = 1; tdi = ~rst_pin; step();
        capture_dr = 0; shift_dr = 0;
        chk("R9 tdo holds captured rst_pin", 64'(tdo), 64'(rst_pin));

        // R2: test-logic-reset clears latches and chain.
        cur = "R2";
        update_dr = 1; step(); update_dr = 0;
        tlr = 1; shift_dr = 1; update_dr = 1; step(); idle();
        chk("R2 pre_in cleared", 64'(pre_in), 64'd0);
        step();

        // R10: latency of a single one through a zeroed chain.
        cur = "R10";
        edges = 0;
        shift_dr = 1; tdi = 1;
        step(); edges++;
        tdi = 0;
        while (tdo !== 1'b1 && edges < 2 * LEN) begin step(); edges++; end
        chk("R10 tdi-to-tdo edges", 64'(edges), 64'(LEN));
        shift_dr = 0;

        // R4: random mix of strobes and data.
        cur = "R4 random";
        for (int i = 0; i < 400; i++) begin
            randomize_pads();
            tdi        = 1'($urandom);
            sel        = ($urandom % 8) != 0;
            capture_dr = ($urandom % 6) == 0;
            shift_dr   = ($urandom % 2) == 0;
            update_dr  = ($urandom % 5) == 0;
            tlr        = ($urandom % 50) == 0;
            step();
        end
        idle();

        // R1: reset mid-run clears everything again.
        cur = "R1 mid-run";
        trst_n = 0; step(); step();
        chk("R1 pre_out after mid reset", 64'(pre_out), 64'd0);
        trst_n = 1; step();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule